// File: doc/BRIEF.md
# Compare-and-Skip Instruction Executor

This block runs two byte-oriented compare instructions for a small 8-bit accumulator core. An instruction word is issued together with the working register, the bank select value, an extended-mode flag and a pointer. The block decodes the word and forms a 12-bit data address. It reads that location from an internal byte array, which is loaded through a simple write port. It then compares the byte with the working register as unsigned numbers.

A compare that comes out true sets no flag. It squashes the instruction that the core has already fetched, so the block reports a skip and stays busy for the no-op cycles. There is one extra cycle when the following instruction is a single word. There are two extra cycles when it is a two-word instruction. At the end the block reports the total cycle count. Neither the working register nor the data byte is ever written.

Top module: `cmpskip_unit`

## Requirements
- R1: Bits [15:9] of the instruction select the operation: 7'b0110010 is "skip if greater" and 7'b0110000 is "skip if less". Bit 8 is the bank bit and bits [7:0] are the operand. Any other value of bits [15:9] is ignored and `busy` stays low.
- R2: With bank bit 1, the data address is {bankSel, operand}.
- R3: With bank bit 0 and extended mode off, operands below 0x60 address 0x000 plus the operand, and operands of 0x60 or more address 0xF00 plus the operand.
- R4: With bank bit 0 and extended mode on, an operand of 0x5F or less addresses idxPtr plus the operand, modulo 4096. Operands of 0x60 or more still use the upper page as in R3.
- R5: The comparison is unsigned. "Greater" skips only when data > working register, "less" skips only when data < working register, and equal values never skip.
- R6: `skipPulse` is high for exactly one cycle, two cycles after the accepting edge. That cycle lies inside the busy window.
- R7: `cycleCount` is 1 without a skip, 2 for a skip over a one-word instruction and 3 for a skip over a two-word instruction. `nextTwoWord` is sampled in the compare cycle and has no effect when there is no skip.
- R8: `busy` is high for exactly `cycleCount` consecutive cycles, starting the cycle after acceptance. `doneStrobe` pulses in the cycle after `busy` falls, and `cycleCount` is valid from that cycle on.
- R9: Executing a compare writes nothing. The same instruction repeated with the same inputs gives the same result.
- R10: After reset, `busy`, `skipPulse` and `doneStrobe` are low and `cycleCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Instruction offered this cycle (taken when idle) |
| instrWord | input | 16 | Instruction word |
| workReg | input | 8 | Working register value |
| bankSel | input | 4 | Bank select register |
| extMode | input | 1 | Extended instruction mode enable |
| idxPtr | input | 12 | Base pointer for indexed literal offset addressing |
| nextTwoWord | input | 1 | The instruction after this one is two words long |
| memWrEn | input | 1 | Preload write enable |
| memWrAddr | input | 12 | Preload write address |
| memWrData | input | 8 | Preload write data |
| busy | output | 1 | Instruction in execution |
| skipPulse | output | 1 | One-cycle pulse: fetched instruction squashed |
| doneStrobe | output | 1 | One-cycle pulse after completion |
| cycleCount | output | 2 | Cycles taken by the last instruction |

## Verification
The bench builds the block with its default widths: a 12-bit address, an 8-bit operand, a 4-bit bank select and an access split at 0x60. Together these make every address path reachable. That includes both access-bank halves on either side of the 0x5F/0x60 boundary, arbitrary banks, and the indexed sum that wraps past 0xFFF. Because the whole 4096-byte array is preloaded with a value equal to the working register, a read from the wrong address shows up as a missing skip or a wrong cycle count. The tests cover all four combinations of compare outcome and following-instruction length, in both compare forms.

// File: rtl/cmpskip_pkg.sv
package cmpskip_pkg;

  localparam logic [6:0] OPC_GT = 7'b0110010;
  localparam logic [6:0] OPC_LT = 7'b0110000;
  localparam int CNT_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_NOP1 = 2'd2,
    ST_NOP2 = 2'd3
  } execState_t;

  // control -> datapath
  typedef struct packed {
    logic capture;   // latch decoded fields and operands
    logic sampleTw;  // latch the two-word flag of the next instruction
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic legal;     // current instruction word is one of the two compares
    logic cond;      // skip condition of the captured compare
    logic twoWord;   // latched two-word flag
  } dpStat_t;

endpackage

// File: rtl/cmpskip_regfile.sv
module cmpskip_regfile #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  assign rdData = store[rdAddr];
endmodule

// File: rtl/cmpskip_dpath.sv
module cmpskip_dpath
  import cmpskip_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OPND_W = 8,
  parameter int DATA_W = 8,
  parameter int ACCESS_SPLIT = 'h60
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [15:0]           instrWord,
  input  logic [DATA_W-1:0]     workReg,
  input  logic [ADDR_W-OPND_W-1:0] bankSel,
  input  logic                  extMode,
  input  logic [ADDR_W-1:0]     idxPtr,
  input  logic                  nextTwoWord,
  input  logic                  memWrEn,
  input  logic [ADDR_W-1:0]     memWrAddr,
  input  logic [DATA_W-1:0]     memWrData,
  output dpStat_t               stat
);
  localparam int BANK_W = ADDR_W - OPND_W;
  localparam logic [OPND_W-1:0] SPLIT = OPND_W'(ACCESS_SPLIT);

  logic [OPND_W-1:0] opnd;
  logic              bankBit;
  logic              isGtNow;
  logic [ADDR_W-1:0] addrNow;

  logic              isGtQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wQ;
  logic              twQ;
  logic [DATA_W-1:0] rdData;

  assign opnd    = instrWord[OPND_W-1:0];
  assign bankBit = instrWord[8];
  assign isGtNow = (instrWord[15:9] == OPC_GT);

  // effective address formation
  always_comb begin
    if (bankBit) begin
      addrNow = {bankSel, opnd};
    end else if (opnd < SPLIT) begin
      if (extMode) addrNow = idxPtr + ADDR_W'(opnd);
      else         addrNow = {{BANK_W{1'b0}}, opnd};
    end else begin
      addrNow = {{BANK_W{1'b1}}, opnd};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isGtQ <= 1'b0;
      addrQ <= '0;
      wQ    <= '0;
      twQ   <= 1'b0;
    end else begin
      if (strobes.capture) begin
        isGtQ <= isGtNow;
        addrQ <= addrNow;
        wQ    <= workReg;
      end
      if (strobes.sampleTw) twQ <= nextTwoWord;
    end
  end

  cmpskip_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regfile (
    .clk    (clk),
    .wrEn   (memWrEn),
    .wrAddr (memWrAddr),
    .wrData (memWrData),
    .rdAddr (addrQ),
    .rdData (rdData)
  );

  assign stat.legal   = isGtNow || (instrWord[15:9] == OPC_LT);
  assign stat.cond    = isGtQ ? (rdData > wQ) : (rdData < wQ);
  assign stat.twoWord = twQ;
endmodule

// File: rtl/cmpskip_ctrl.sv
module cmpskip_ctrl
  import cmpskip_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  dpStat_t          stat,
  output ctrlStrobes_t     strobes,
  output logic             busy,
  output logic             skipPulse,
  output logic             doneStrobe,
  output logic [CNT_W-1:0] cycleCount
);
  execState_t state;
  logic       accept;

  assign accept           = (state == ST_IDLE) && issueValid && stat.legal;
  assign strobes.capture  = accept;
  assign strobes.sampleTw = (state == ST_EXEC);
  assign busy             = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      skipPulse  <= 1'b0;
      doneStrobe <= 1'b0;
      cycleCount <= '0;
    end else begin
      skipPulse  <= 1'b0;
      doneStrobe <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) state <= ST_EXEC;
        ST_EXEC: begin
          skipPulse <= stat.cond;
          if (stat.cond) begin
            state <= ST_NOP1;
          end else begin
            state      <= ST_IDLE;
            doneStrobe <= 1'b1;
            cycleCount <= CNT_W'(1);
          end
        end
        ST_NOP1: begin
          if (stat.twoWord) begin
            state <= ST_NOP2;
          end else begin
            state      <= ST_IDLE;
            doneStrobe <= 1'b1;
            cycleCount <= CNT_W'(2);
          end
        end
        ST_NOP2: begin
          state      <= ST_IDLE;
          doneStrobe <= 1'b1;
          cycleCount <= CNT_W'(3);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmpskip_unit.sv
module cmpskip_unit
  import cmpskip_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OPND_W = 8,
  parameter int DATA_W = 8,
  parameter int ACCESS_SPLIT = 'h60
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      issueValid,
  input  logic [15:0]               instrWord,
  input  logic [DATA_W-1:0]         workReg,
  input  logic [ADDR_W-OPND_W-1:0]  bankSel,
  input  logic                      extMode,
  input  logic [ADDR_W-1:0]         idxPtr,
  input  logic                      nextTwoWord,
  input  logic                      memWrEn,
  input  logic [ADDR_W-1:0]         memWrAddr,
  input  logic [DATA_W-1:0]         memWrData,
  output logic                      busy,
  output logic                      skipPulse,
  output logic                      doneStrobe,
  output logic [CNT_W-1:0]          cycleCount
);
  ctrlStrobes_t strobes;
  dpStat_t      stat;

  cmpskip_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .stat       (stat),
    .strobes    (strobes),
    .busy       (busy),
    .skipPulse  (skipPulse),
    .doneStrobe (doneStrobe),
    .cycleCount (cycleCount)
  );

  cmpskip_dpath #(
    .ADDR_W(ADDR_W), .OPND_W(OPND_W), .DATA_W(DATA_W), .ACCESS_SPLIT(ACCESS_SPLIT)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .instrWord   (instrWord),
    .workReg     (workReg),
    .bankSel     (bankSel),
    .extMode     (extMode),
    .idxPtr      (idxPtr),
    .nextTwoWord (nextTwoWord),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .stat        (stat)
  );
endmodule

// File: rtl/cmpskip_chk.sv
module cmpskip_chk (
  input logic        clk,
  input logic        rstN,
  input logic        issueValid,
  input logic [15:0] instrWord,
  input logic        busy,
  input logic        skipPulse,
  input logic        doneStrobe,
  input logic [1:0]  cycleCount
);
  logic [2:0] runLen;
  logic       prevBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen   <= '0;
      prevBusy <= 1'b0;
    end else begin
      prevBusy <= busy;
      if (busy) runLen <= prevBusy ? runLen + 3'd1 : 3'd1;
    end
  end

  // R1: unknown opcodes leave the block idle
  a_r1_illegal_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && issueValid && instrWord[15:9] != 7'b0110010 && instrWord[15:9] != 7'b0110000)
      |=> !busy);

  // R6: skip pulse lasts one cycle and lies inside the busy window
  a_r6_skip_single: assert property (@(posedge clk) disable iff (!rstN)
    skipPulse |=> !skipPulse);
  a_r6_skip_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    skipPulse |-> busy);

  // R7: reported count is always 1..3
  a_r7_count_range: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (cycleCount != 2'd0));

  // R8: busy window length equals reported count, done follows busy
  a_r8_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (runLen == {1'b0, cycleCount}));
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (!busy && $past(busy)));
endmodule

bind cmpskip_unit cmpskip_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .instrWord  (instrWord),
  .busy       (busy),
  .skipPulse  (skipPulse),
  .doneStrobe (doneStrobe),
  .cycleCount (cycleCount)
);

// File: tb/test_cmpskip_unit.sv
`timescale 1ns/1ps
module test_cmpskip_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [7:0]  workReg = '0;
  logic [3:0]  bankSel = '0;
  logic        extMode = 1'b0;
  logic [11:0] idxPtr = '0;
  logic        nextTwoWord = 1'b0;
  logic        memWrEn = 1'b0;
  logic [11:0] memWrAddr = '0;
  logic [7:0]  memWrData = '0;
  logic        busy, skipPulse, doneStrobe;
  logic [1:0]  cycleCount;

  int checks = 0;
  int fails = 0;
  logic [7:0] shadow [4096];

  always #2 clk = ~clk;

  cmpskip_unit i_cmpskip_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .workReg(workReg), .bankSel(bankSel), .extMode(extMode), .idxPtr(idxPtr),
    .nextTwoWord(nextTwoWord), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .busy(busy), .skipPulse(skipPulse),
    .doneStrobe(doneStrobe), .cycleCount(cycleCount)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    memWrEn = 1'b1; memWrAddr = a; memWrData = d;
    shadow[a] = d;
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  function automatic logic [11:0] modelAddr(input logic [15:0] iw, input logic [3:0] bs,
                                            input logic ex, input logic [11:0] p);
    logic [7:0] f;
    f = iw[7:0];
    if (iw[8]) return {bs, f};
    if (f >= 8'h60) return 12'hF00 | {4'h0, f};
    if (ex) return p + {4'h0, f};
    return {4'h0, f};
  endfunction

  // Issue one compare, observe it at the ports and compare with the model.
  task automatic runOp(input string req, input logic [15:0] iw, input logic [7:0] w,
                       input logic [3:0] bs, input logic ex, input logic [11:0] p,
                       input logic tw);
    logic [7:0] d;
    bit expSkip;
    int expCnt, busyN, skipN, cntSeen, skipAt;
    bit done;
    d = shadow[modelAddr(iw, bs, ex, p)];
    expSkip = (iw[15:9] == 7'b0110010) ? (d > w) : (d < w);
    expCnt  = expSkip ? (tw ? 3 : 2) : 1;
    @(negedge clk);
    issueValid = 1'b1; instrWord = iw; workReg = w; bankSel = bs;
    extMode = ex; idxPtr = p; nextTwoWord = tw;
    @(negedge clk);
    issueValid = 1'b0;
    busyN = 0; skipN = 0; cntSeen = 0; done = 0; skipAt = 0;
    for (int k = 1; k <= 8 && !done; k++) begin
      if (busy) busyN++;
      if (skipPulse) begin skipN++; skipAt = k; end
      if (doneStrobe) begin done = 1; cntSeen = cycleCount; end
      if (!done) @(negedge clk);
    end
    nextTwoWord = 1'b0;
    chk(done, req, "done seen", int'(done), 1);
    chk(skipN == (expSkip ? 1 : 0), req, "skip pulses", skipN, expSkip ? 1 : 0);
    if (expSkip) chk(skipAt == 2, "R6", "skip pulse cycle", skipAt, 2);
    chk(cntSeen == expCnt, req, "cycleCount (R7)", cntSeen, expCnt);
    chk(busyN == expCnt, "R8", "busy cycles", busyN, expCnt);
  endtask

  task automatic tReset();
    chk(busy == 1'b0, "R10", "busy after reset", busy, 0);
    chk(skipPulse == 1'b0, "R10", "skip after reset", skipPulse, 0);
    chk(doneStrobe == 1'b0, "R10", "done after reset", doneStrobe, 0);
    chk(cycleCount == 2'd0, "R10", "count after reset", cycleCount, 0);
  endtask

  task automatic tPreload();
    for (int a = 0; a < 4096; a++) poke(12'(a), 8'h50);
  endtask

  task automatic tGreater();
    poke(12'h020, 8'h90);
    poke(12'h021, 8'h10);
    poke(12'h022, 8'h50);
    runOp("R5", 16'h6420, 8'h50, 4'h0, 1'b0, 12'h0, 1'b0);  // skip, one word
    runOp("R7", 16'h6420, 8'h50, 4'h0, 1'b0, 12'h0, 1'b1);  // skip, two words
    runOp("R5", 16'h6421, 8'h50, 4'h0, 1'b0, 12'h0, 1'b0);  // below: no skip
    runOp("R7", 16'h6421, 8'h50, 4'h0, 1'b0, 12'h0, 1'b1);  // two-word ignored
    runOp("R5", 16'h6422, 8'h50, 4'h0, 1'b0, 12'h0, 1'b1);  // equal
  endtask

  task automatic tLess();
    runOp("R5", 16'h6021, 8'h50, 4'h0, 1'b0, 12'h0, 1'b0);
    runOp("R7", 16'h6021, 8'h50, 4'h0, 1'b0, 12'h0, 1'b1);
    runOp("R5", 16'h6020, 8'h50, 4'h0, 1'b0, 12'h0, 1'b1);
    runOp("R5", 16'h6022, 8'h50, 4'h0, 1'b0, 12'h0, 1'b0);
  endtask

  task automatic tUnsigned();
    poke(12'h024, 8'h80);
    poke(12'h025, 8'hFF);
    runOp("R5", 16'h6424, 8'h7F, 4'h0, 1'b0, 12'h0, 1'b0);  // 0x80 > 0x7F
    runOp("R5", 16'h6025, 8'h01, 4'h0, 1'b0, 12'h0, 1'b0);  // 0xFF not < 0x01
  endtask

  task automatic tBanked();
    poke(12'h530, 8'h90);
    runOp("R2", 16'h6530, 8'h50, 4'h5, 1'b0, 12'h0, 1'b0);
    runOp("R2", 16'h6530, 8'h50, 4'h6, 1'b0, 12'h0, 1'b0);
  endtask

  task automatic tAccess();
    poke(12'hF80, 8'h90);
    poke(12'h05F, 8'h90);
    poke(12'hF60, 8'h90);
    runOp("R3", 16'h6480, 8'h50, 4'h3, 1'b0, 12'h0, 1'b0);
    runOp("R3", 16'h645F, 8'h50, 4'h3, 1'b0, 12'h0, 1'b1);
    runOp("R3", 16'h6460, 8'h50, 4'h3, 1'b0, 12'h0, 1'b0);
    runOp("R4", 16'h6480, 8'h50, 4'h3, 1'b1, 12'h200, 1'b0);
  endtask

  task automatic tIndexed();
    poke(12'h310, 8'h90);
    poke(12'h015, 8'h90);
    runOp("R4", 16'h6410, 8'h50, 4'h0, 1'b1, 12'h300, 1'b0);
    runOp("R4", 16'h6425, 8'h50, 4'h0, 1'b1, 12'hFF0, 1'b1);  // wraps to 0x015
    runOp("R4", 16'h6410, 8'h50, 4'h0, 1'b0, 12'h300, 1'b0);  // ext off: 0x010
  endtask

  task automatic tRepeat();
    runOp("R9", 16'h6420, 8'h50, 4'h0, 1'b0, 12'h0, 1'b0);
    runOp("R9", 16'h6420, 8'h50, 4'h0, 1'b0, 12'h0, 1'b0);
  endtask

  task automatic tIllegal();
    int busySeen;
    busySeen = 0;
    @(negedge clk);
    issueValid = 1'b1; instrWord = 16'h6220;
    @(negedge clk);
    instrWord = 16'h6620;
    @(negedge clk);
    issueValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (busy || doneStrobe) busySeen++;
      @(negedge clk);
    end
    chk(busySeen == 0, "R1", "busy/done on unknown opcode", busySeen, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tPreload();
    tGreater();
    tLess();
    tUnsigned();
    tBanked();
    tAccess();
    tIndexed();
    tRepeat();
    tIllegal();
    report();
  end
endmodule